// File: doc/BRIEF.md
# Low-Power Mode Quiesce Sequencer

This block steps a processor core between normal execution and one of three reduced-power states: a light state (doze), a medium state (nap) and a deep state (sleep). The core supplies three mode-enable bits and a one-cycle power-down request strobe. When the strobe arrives while the core is running and at least one enable is set, the block picks the deepest enabled state and begins the entry sequence.

Doze is entered directly. Nap and sleep first need permission from the system. The block raises a quiesce request and waits for the system's acknowledge. It then lets a fixed number of settling clocks pass before it shuts off bus snooping. Each state leaves its own set of functions alive: snooping, the time base and the clock generator. In sleep, a flag tells the system that it may bypass and stop the clock source. A wake-up input (interrupt, reset request and so on) returns the core to run from any state, including a handshake still in progress.

Top module: `lpm_quiesce_ctrl`

## Requirements
- R1: During and right after synchronous reset, `cur_mode` is 0 (run), `qreq` and `pll_off_ok` are 0, and `snoop_en`, `tbase_en` and `pll_en` are 1.
- R2: The block leaves run only when `pdn_set` is sampled high, `wake` is low and at least one `mode_en` bit is set. A strobe with all enables clear is ignored, and so is a strobe in any state other than run; the outputs stay as they were.
- R3: `mode_en` bit 0 enables doze, bit 1 enables nap and bit 2 enables sleep. When several bits are set, sleep wins over nap and nap wins over doze. The choice is fixed when the strobe is sampled, and later changes to `mode_en` have no effect on the entry in progress.
- R4: Doze is entered on the clock edge that samples the strobe. In doze `cur_mode` is 1, `qreq` is 0 and snooping, time base and clock generator stay enabled.
- R5: For nap or sleep, `qreq` rises on the edge that samples the strobe. `cur_mode` stays 0 and snooping stays on until the mode is entered.
- R6: With `qack` first sampled high at edge k during the wait, the mode is entered at edge k+SETTLE_CYC (default 8). Dropping `qack` during the settling interval has no effect.
- R7: In nap `cur_mode` is 2, `qreq` is 1, `snoop_en` is 0, and `tbase_en` and `pll_en` are 1.
- R8: In sleep `cur_mode` is 3, `qreq` is 1, and `snoop_en`, `tbase_en` and `pll_en` are 0. `pll_off_ok` is 1 in sleep and only in sleep.
- R9: `wake` sampled high in any state outside run returns the block to run on that edge, with all outputs at their R1 values. This aborts a handshake during the acknowledge wait or the settling interval. `wake` takes priority over `pdn_set` and `qack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 3 | Mode enables: bit 0 doze, bit 1 nap, bit 2 sleep |
| pdn_set | input | 1 | Power-down request strobe |
| wake | input | 1 | Wake-up event |
| qack | input | 1 | Quiesce acknowledge from system logic |
| qreq | output | 1 | Quiesce request to system logic |
| snoop_en | output | 1 | Bus snooping enable |
| tbase_en | output | 1 | Time base enable |
| pll_en | output | 1 | Clock generator enable |
| pll_off_ok | output | 1 | System may bypass and stop the clock source |
| cur_mode | output | 2 | Mode in effect: 0 run, 1 doze, 2 nap, 3 sleep |

## Verification
The bench targets the exact settling count. A design that counts from the request rather than from the acknowledge, or that is off by one, enters nap or sleep an edge early or late, and snooping turns off at the wrong cycle. It also wakes the block during the acknowledge wait and in the middle of the settling interval, and drops the acknowledge partway through settling. A design that mishandles these keeps `qreq` raised or still enters the mode after the wake. Strobes with no enables, strobes while already asleep, wake colliding with a strobe, and all three enables set followed by enable changes each expose a design that enters the wrong state or re-evaluates the enables too late.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int EN_W = 3;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DOZE   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_NAP    = 3'd4,
    ST_SLEEP  = 3'd5
  } lp_state_e;

  typedef enum logic [1:0] {
    LM_RUN   = 2'd0,
    LM_DOZE  = 2'd1,
    LM_NAP   = 2'd2,
    LM_SLEEP = 2'd3
  } lp_mode_e;
endpackage

// File: rtl/lpm_prio.sv
module lpm_prio
  import lpm_pkg::*;
(
  input  logic [EN_W-1:0] en,
  output lp_mode_e        sel
);
  // deepest enabled mode wins; bit index + 1 equals the mode code
  always_comb begin
    sel = LM_RUN;
    for (int i = 0; i < EN_W; i++) begin
      if (en[i]) sel = lp_mode_e'(i + 1);
    end
  end
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lpm_out_map.sv
module lpm_out_map
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lp_state_e st_nxt,
  output logic      qreq,
  output logic      snoop_en,
  output logic      tbase_en,
  output logic      pll_en,
  output logic      pll_off_ok,
  output lp_mode_e  mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      qreq <= 1'b0; snoop_en <= 1'b1; tbase_en <= 1'b1;
      pll_en <= 1'b1; pll_off_ok <= 1'b0; mode <= LM_RUN;
    end else begin
      qreq <= 1'b0; snoop_en <= 1'b1; tbase_en <= 1'b1;
      pll_en <= 1'b1; pll_off_ok <= 1'b0; mode <= LM_RUN;
      unique case (st_nxt)
        ST_DOZE:   mode <= LM_DOZE;
        ST_WAIT,
        ST_SETTLE: qreq <= 1'b1;
        ST_NAP: begin
          qreq <= 1'b1; snoop_en <= 1'b0; mode <= LM_NAP;
        end
        ST_SLEEP: begin
          qreq <= 1'b1; snoop_en <= 1'b0; tbase_en <= 1'b0;
          pll_en <= 1'b0; pll_off_ok <= 1'b1; mode <= LM_SLEEP;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lpm_quiesce_ctrl.sv
module lpm_quiesce_ctrl
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EN_W-1:0] mode_en,
  input  logic            pdn_set,
  input  logic            wake,
  input  logic            qack,
  output logic            qreq,
  output logic            snoop_en,
  output logic            tbase_en,
  output logic            pll_en,
  output logic            pll_off_ok,
  output logic [1:0]      cur_mode
);
  lp_state_e st_q, st_nxt;
  lp_mode_e  tgt_q, tgt_nxt, sel;
  lp_mode_e  mode_q;
  logic      settle_done;

  lpm_prio u_prio (.en(mode_en), .sel(sel));

  lpm_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .clr(st_q != ST_SETTLE), .done(settle_done)
  );

  always_comb begin
    st_nxt  = st_q;
    tgt_nxt = tgt_q;
    unique case (st_q)
      ST_RUN: begin
        if (pdn_set && !wake && sel != LM_RUN) begin
          tgt_nxt = sel;
          st_nxt  = (sel == LM_DOZE) ? ST_DOZE : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (wake)      st_nxt = ST_RUN;
        else if (qack) st_nxt = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (wake)             st_nxt = ST_RUN;
        else if (settle_done) st_nxt = (tgt_q == LM_SLEEP) ? ST_SLEEP : ST_NAP;
      end
      ST_DOZE, ST_NAP, ST_SLEEP: begin
        if (wake) st_nxt = ST_RUN;
      end
      default: st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RUN;
      tgt_q <= LM_RUN;
    end else begin
      st_q  <= st_nxt;
      tgt_q <= tgt_nxt;
    end
  end

  lpm_out_map u_out (
    .clk(clk), .rst(rst), .st_nxt(st_nxt),
    .qreq(qreq), .snoop_en(snoop_en), .tbase_en(tbase_en),
    .pll_en(pll_en), .pll_off_ok(pll_off_ok), .mode(mode_q)
  );

  assign cur_mode = mode_q;
endmodule

// File: rtl/lpm_quiesce_ctrl_chk.sv
module lpm_quiesce_ctrl_chk #(
  parameter int SETTLE_CYC = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       pdn_set,
  input logic       wake,
  input logic       qack,
  input logic       qreq,
  input logic       snoop_en,
  input logic       tbase_en,
  input logic       pll_en,
  input logic       pll_off_ok,
  input logic [1:0] cur_mode
);
  localparam int CW = $clog2(SETTLE_CYC + 2) + 1;
  localparam logic [CW-1:0] FULL = CW'(SETTLE_CYC + 1);

  // edges since the acknowledge was first seen while the request is raised
  logic [CW-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst || !qreq) seen <= '0;
    else if ((qack || seen != '0) && seen != FULL) seen <= seen + 1'b1;
  end

  AST_HOLD_RUN: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == 2'd0 && !qreq && !pdn_set) |=> (cur_mode == 2'd0 && !qreq)); // R2
  AST_DOZE_ALIVE: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == 2'd1) |-> (snoop_en && tbase_en && pll_en && !qreq)); // R4
  AST_SNOOP_UNTIL_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (qreq && cur_mode == 2'd0) |-> snoop_en); // R5
  AST_SETTLE_SPAN: assert property (@(posedge clk) disable iff (rst)
    $rose(cur_mode[1]) |-> (seen == FULL)); // R6
  AST_DEEP_QUIESCED: assert property (@(posedge clk) disable iff (rst)
    cur_mode[1] |-> (qreq && !snoop_en)); // R7
  AST_CLK_STOP_SLEEP_ONLY: assert property (@(posedge clk) disable iff (rst)
    pll_off_ok |-> (cur_mode == 2'd3 && !tbase_en && !pll_en)); // R8
  AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (rst)
    wake |=> (cur_mode == 2'd0 && !qreq && snoop_en && tbase_en && pll_en)); // R9
endmodule

bind lpm_quiesce_ctrl lpm_quiesce_ctrl_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst(rst), .pdn_set(pdn_set), .wake(wake), .qack(qack),
  .qreq(qreq), .snoop_en(snoop_en), .tbase_en(tbase_en), .pll_en(pll_en),
  .pll_off_ok(pll_off_ok), .cur_mode(cur_mode)
);

// File: tb/lpm_quiesce_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_quiesce_ctrl_tb;
  localparam int SETTLE_CYC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_en = '0;
  logic       pdn_set = 1'b0, wake = 1'b0, qack = 1'b0;
  logic       qreq, snoop_en, tbase_en, pll_en, pll_off_ok;
  logic [1:0] cur_mode;

  int n_cmp = 0, n_bad = 0;
  // reference state: 0 run, 1 doze, 2 wait, 3 settle, 4 nap, 5 sleep
  int m_st = 0, m_tgt = 0, m_cnt = 0;

  always #2 clk = ~clk;

  lpm_quiesce_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_dut (
    .clk(clk), .rst(rst), .mode_en(mode_en), .pdn_set(pdn_set), .wake(wake),
    .qack(qack), .qreq(qreq), .snoop_en(snoop_en), .tbase_en(tbase_en),
    .pll_en(pll_en), .pll_off_ok(pll_off_ok), .cur_mode(cur_mode)
  );

  // {mode, qreq, snoop, tbase, pll, clk-stop ok}
  function automatic logic [6:0] exp_of(int st);
    case (st)
      1:       return {2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      2, 3:    return {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
      4:       return {2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
      5:       return {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
      default: return {2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    endcase
  endfunction

  function automatic string tag_of(int st);
    case (st)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic model_step();
    case (m_st)
      0: if (pdn_set && !wake && mode_en != 3'b000) begin
           m_tgt = mode_en[2] ? 5 : (mode_en[1] ? 4 : 1);
           m_st  = (m_tgt == 1) ? 1 : 2;
         end
      2: if (wake) m_st = 0;
         else if (qack) begin m_st = 3; m_cnt = 1; end
      3: if (wake) m_st = 0;
         else if (m_cnt == SETTLE_CYC) m_st = m_tgt;
         else m_cnt++;
      default: if (wake) m_st = 0;
    endcase
  endtask

  task automatic cmp(string tag);
    logic [6:0] act, exp;
    act = {cur_mode, qreq, snoop_en, tbase_en, pll_en, pll_off_ok};
    exp = exp_of(m_st);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    cmp(tag_of(m_st));
  endtask

  task automatic quiet();
    pdn_set = 1'b0; wake = 1'b0; qack = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: got no completion expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    cmp("R1");
    rst = 1'b0;
    @(negedge clk);
    cmp("R1");

    // R2: strobe with no enables is ignored
    mode_en = 3'b000; pdn_set = 1'b1; step(); quiet(); step();

    // R4: doze, then a strobe while dozing is ignored, then wake (R9)
    mode_en = 3'b001; pdn_set = 1'b1; step(); quiet(); step();
    mode_en = 3'b110; pdn_set = 1'b1; step(); cmp("R2"); quiet();
    wake = 1'b1; step(); cmp("R9"); quiet(); step();

    // R5/R6/R7: nap with late ack, ack dropped during settle
    mode_en = 3'b010; pdn_set = 1'b1; step(); quiet();
    repeat (4) step();
    qack = 1'b1; step(); qack = 1'b0;
    repeat (SETTLE_CYC + 2) step();
    wake = 1'b1; step(); cmp("R9"); quiet();

    // R3/R8: all enables set, enables cleared after the strobe
    mode_en = 3'b111; pdn_set = 1'b1; step(); quiet(); mode_en = 3'b000;
    qack = 1'b1; step(); qack = 1'b0;
    repeat (SETTLE_CYC + 1) step();
    cmp("R3");
    pdn_set = 1'b1; mode_en = 3'b001; step(); cmp("R2"); quiet();
    wake = 1'b1; step(); cmp("R9"); quiet();

    // R9: abort while waiting for ack, wake and ack together
    mode_en = 3'b100; pdn_set = 1'b1; step(); quiet();
    repeat (2) step();
    wake = 1'b1; qack = 1'b1; step(); cmp("R9"); quiet();
    repeat (SETTLE_CYC + 2) step();

    // R9: abort in the middle of settling
    mode_en = 3'b010; pdn_set = 1'b1; step(); quiet();
    qack = 1'b1; step(); qack = 1'b0;
    repeat (3) step();
    wake = 1'b1; step(); cmp("R9"); quiet();
    repeat (SETTLE_CYC + 2) step();

    // R9: wake beats a simultaneous strobe in run
    mode_en = 3'b100; pdn_set = 1'b1; wake = 1'b1; step(); cmp("R9"); quiet();

    // random traffic
    for (int i = 0; i < 5000; i++) begin
      mode_en = 3'($urandom_range(0, 7));
      pdn_set = ($urandom_range(0, 5) == 0);
      wake    = ($urandom_range(0, 29) == 0);
      qack    = ($urandom_range(0, 3) == 0);
      step();
    end
    quiet();
    finish_run();
  end
endmodule